// File: doc/BRIEF.md
# Normalized Min-Sum Check Node Unit

This unit computes the check-node update for one parity-check row of an iterative LDPC decoder. Each edge of the row carries a signed variable-to-check message from the previous iteration. The messages arrive one per cycle. Markers flag the first and the last edge of the row. The row degree can be anything from 2 to 32 edges.

While the row streams in, the unit keeps a running summary of the row:

- the smallest magnitude seen;
- the second-smallest magnitude;
- the edge position where the smallest magnitude occurred;
- the parity of all sign bits;
- each edge's own sign bit.

When the last edge is accepted, this summary is copied into an output stage. The output stage then replays the row, one extrinsic check-to-variable message per cycle, in the order the edges arrived. Each reply leaves out the contribution of its own edge, both from the sign and from the minimum. The reply magnitude is scaled by a factor of three quarters.

Because the summary is copied into the output stage, the next row can stream in while the previous row is still being replayed.

Top module: `nms_check_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_first` and `out_last` are low, and no output appears until a row's last edge is accepted.
- R2: An output for an edge that is not the stored minimum position carries the smallest input magnitude of the row.
- R3: The output for the edge where the row minimum first occurred carries the second-smallest magnitude, which is the smallest over all other edges.
- R4: The output sign is negative exactly when the XOR of the sign bits (bit 7) of all other edges is 1.
- R5: The output magnitude is m − floor(m/4), where m is the selected minimum, so no output magnitude exceeds 96. The output is 8-bit two's complement, and a zero magnitude is always sent as 0.
- R6: An input of −128 is treated as magnitude 127 with a negative sign.
- R7: The first output appears in the cycle after the edge with `in_last` is accepted. Outputs then follow back-to-back, one per edge, in input order. `out_first` is high on the first output and `out_last` is high on the final output.
- R8: Any row degree from 2 to 32 is handled. An input with `in_first` high discards any unfinished row and starts a new one.
- R9: When several edges tie for the minimum magnitude, only the earliest of them is the stored minimum position. Every edge then receives that same magnitude, because the second minimum equals it.
- R10: A new row may stream in while the previous row's outputs drain. This holds as long as the new row's last edge arrives no earlier than the cycle in which the previous row's final output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input message present this cycle |
| in_msg | input | 8 | Variable-to-check message, two's complement |
| in_first | input | 1 | Marks the first edge of a row |
| in_last | input | 1 | Marks the last edge of a row |
| out_valid | output | 1 | Output message present this cycle |
| out_msg | output | 8 | Check-to-variable message, two's complement |
| out_first | output | 1 | Marks the reply for the first edge |
| out_last | output | 1 | Marks the reply for the last edge |

## Verification
Inputs are driven on the falling edge. The reply for edge 0 is due in the cycle that follows the rising edge that accepts the last input, and each later reply comes exactly one cycle after the one before it. The bench therefore samples each reply on the falling edge that follows its rising edge. The bench also expects `out_valid` to be low on the falling edge right after the final reply.

In the overlapped-row scenario, the replies of one row are checked on the same falling edges that drive the next row. This is safe because the outputs depend only on registers. Expected values come from a brute-force model in the bench, which recomputes, for each edge, the minimum and the sign parity over all the other edges.

// File: rtl/nms_pkg.sv
package nms_pkg;
    parameter int MSG_W   = 8;
    parameter int MAX_DEG = 32;
    localparam int IDX_W  = $clog2(MAX_DEG);
    localparam int DEG_W  = IDX_W + 1;
    localparam int MAG_W  = MSG_W - 1;

    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [MAG_W-1:0] mag_t;

    // Running row summary carried from the scanner to the reply stage
    typedef struct packed {
        mag_t             min1;
        mag_t             min2;
        logic [IDX_W-1:0] idx;
        logic             sx;
    } row_sum_t;

    localparam row_sum_t SUM_INIT = '{min1: '1, min2: '1, idx: '0, sx: 1'b0};

    // Symmetric saturation: the most negative code maps to the largest magnitude
    function automatic mag_t sat_mag(msg_t m);
        msg_t n;
        n = -m;
        if (m == {1'b1, {MAG_W{1'b0}}}) return '1;
        else if (m[MSG_W-1])             return n[MAG_W-1:0];
        else                             return m[MAG_W-1:0];
    endfunction

    // Scale by 0.75 with truncation
    function automatic mag_t normalize(mag_t x);
        return x - (x >> 2);
    endfunction

    function automatic msg_t apply_sign(mag_t m, logic s);
        msg_t p;
        p = {1'b0, m};
        return s ? -p : p;
    endfunction
endpackage

// File: rtl/nms_row_scan.sv
module nms_row_scan
    import nms_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  msg_t               in_msg,
    input  logic               in_first,
    output row_sum_t           sum_nxt,
    output logic [MAX_DEG-1:0] signs_nxt,
    output logic [DEG_W-1:0]   deg_nxt
);
    row_sum_t           sum_q;
    logic [MAX_DEG-1:0] signs_q;
    logic [IDX_W-1:0]   cnt_q;

    row_sum_t           base;
    logic [IDX_W-1:0]   pos;
    mag_t               mag;
    logic               sgn;

    always_comb begin
        base = in_first ? SUM_INIT : sum_q;
        pos  = in_first ? '0 : cnt_q;
        mag  = sat_mag(in_msg);
        sgn  = in_msg[MSG_W-1];

        sum_nxt    = base;
        sum_nxt.sx = base.sx ^ sgn;
        if (mag < base.min1) begin
            sum_nxt.min2 = base.min1;
            sum_nxt.min1 = mag;
            sum_nxt.idx  = pos;
        end else if (mag < base.min2) begin
            sum_nxt.min2 = mag;
        end

        signs_nxt      = in_first ? '0 : signs_q;
        signs_nxt[pos] = sgn;
        deg_nxt        = {1'b0, pos} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= SUM_INIT;
            signs_q <= '0;
            cnt_q   <= '0;
        end else if (in_valid) begin
            sum_q   <= sum_nxt;
            signs_q <= signs_nxt;
            cnt_q   <= pos + 1'b1;
        end
    end

    // R2/R3: the running smallest never exceeds the running second smallest
    assert_min_order_R2: assert property (@(posedge clk) disable iff (rst)
        sum_q.min1 <= sum_q.min2);
endmodule

// File: rtl/nms_reply_gen.sv
module nms_reply_gen
    import nms_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  row_sum_t           sum_in,
    input  logic [MAX_DEG-1:0] signs_in,
    input  logic [DEG_W-1:0]   deg_in,
    output logic               out_valid,
    output msg_t               out_msg,
    output logic               out_first,
    output logic               out_last
);
    row_sum_t           snap_q;
    logic [MAX_DEG-1:0] sign_q;
    logic [DEG_W-1:0]   deg_q;
    logic [IDX_W-1:0]   edge_q;
    logic               active_q;

    logic               at_end;
    mag_t               pick;

    always_comb begin
        at_end    = ({1'b0, edge_q} == deg_q - 1'b1);
        pick      = (edge_q == snap_q.idx) ? snap_q.min2 : snap_q.min1;
        out_msg   = apply_sign(normalize(pick), snap_q.sx ^ sign_q[edge_q]);
        out_valid = active_q;
        out_first = active_q && (edge_q == '0);
        out_last  = active_q && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= SUM_INIT;
            sign_q   <= '0;
            deg_q    <= '0;
            edge_q   <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            snap_q   <= sum_in;
            sign_q   <= signs_in;
            deg_q    <= deg_in;
            edge_q   <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (at_end) active_q <= 1'b0;
            else        edge_q   <= edge_q + 1'b1;
        end
    end

    assert_first_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (out_valid && out_first));

    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last && !load) |=> (out_valid && edge_q == $past(edge_q) + 1'b1));

    assert_quiet_after_row_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && !load) |=> !out_valid);

    assert_scaled_bound_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_msg) <= 96 && $signed(out_msg) >= -96));
endmodule

// File: rtl/nms_check_unit.sv
module nms_check_unit
    import nms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [MSG_W-1:0] in_msg,
    input  logic             in_first,
    input  logic             in_last,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg,
    output logic             out_first,
    output logic             out_last
);
    row_sum_t           sum_nxt;
    logic [MAX_DEG-1:0] signs_nxt;
    logic [DEG_W-1:0]   deg_nxt;

    nms_row_scan scan_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_msg    (in_msg),
        .in_first  (in_first),
        .sum_nxt   (sum_nxt),
        .signs_nxt (signs_nxt),
        .deg_nxt   (deg_nxt)
    );

    nms_reply_gen reply_i (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid && in_last),
        .sum_in    (sum_nxt),
        .signs_in  (signs_nxt),
        .deg_in    (deg_nxt),
        .out_valid (out_valid),
        .out_msg   (out_msg),
        .out_first (out_first),
        .out_last  (out_last)
    );
endmodule

// File: tb/nms_check_unit_tb_top.sv
module nms_check_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_msg;
    logic       in_first;
    logic       in_last;
    logic       out_valid;
    logic [7:0] out_msg;
    logic       out_first;
    logic       out_last;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef logic signed [7:0] row_t [32];
    row_t row_v, row_b;

    always #2 clk = ~clk;

    nms_check_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_msg),
        .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
        .out_msg(out_msg), .out_first(out_first), .out_last(out_last)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Brute-force reference: min and sign parity over all other edges
    function automatic int ref_out(row_t v, int deg, int j);
        int m   = 1000;
        int neg = 0;
        for (int k = 0; k < deg; k++) begin
            if (k != j) begin
                int a = (v[k] < 0) ? -int'(v[k]) : int'(v[k]);
                if (a > 127) a = 127;
                if (a < m) m = a;
                if (v[k] < 0) neg ^= 1;
            end
        end
        m = m - (m / 4);
        return neg ? -m : m;
    endfunction

    task automatic idle();
        in_valid = 0; in_first = 0; in_last = 0; in_msg = '0;
    endtask

    task automatic drive(logic signed [7:0] v, bit f, bit l);
        in_valid = 1; in_msg = v; in_first = f; in_last = l;
    endtask

    task automatic chk_edge(row_t v, int deg, int j, string req);
        chk("R7 valid", out_valid, 1);
        chk("R7 first", out_first, (j == 0));
        chk("R7 last", out_last, (j == deg - 1));
        chk(req, int'($signed(out_msg)), ref_out(v, deg, j));
    endtask

    task automatic run_row(int deg, string req);
        for (int i = 0; i < deg; i++) begin
            @(negedge clk);
            drive(row_v[i], i == 0, i == deg - 1);
        end
        for (int j = 0; j < deg; j++) begin
            @(negedge clk);
            if (j == 0) idle();
            chk_edge(row_v, deg, j, req);
        end
        @(negedge clk);
        chk("R7 end", out_valid, 0);
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 valid", out_valid, 0);
            chk("R1 first", out_first, 0);
            chk("R1 last", out_last, 0);
        end
    endtask

    task automatic t_deg2();
        row_v[0] = 8'sd5; row_v[1] = -8'sd9;
        run_row(2, "R2 R4 R8 deg2");
    endtask

    task automatic t_mixed();
        row_v[0] = 8'sd20; row_v[1] = -8'sd3; row_v[2] = 8'sd40;
        row_v[3] = -8'sd60; row_v[4] = 8'sd7;
        run_row(5, "R2 R3 R4 R5 mixed");
    endtask

    task automatic t_sat();
        row_v[0] = -8'sd128; row_v[1] = -8'sd128; row_v[2] = 8'sd100;
        run_row(3, "R6 saturate");
    endtask

    task automatic t_tie();
        row_v[0] = 8'sd10; row_v[1] = 8'sd10; row_v[2] = 8'sd50; row_v[3] = -8'sd10;
        run_row(4, "R9 tie");
    endtask

    task automatic t_zero();
        row_v[0] = 8'sd0; row_v[1] = -8'sd5; row_v[2] = -8'sd30;
        run_row(3, "R5 zero");
    endtask

    task automatic t_deg32();
        int x = 32'h1d3a;
        for (int i = 0; i < 32; i++) begin
            x = (x * 1103515245 + 12345) & 32'h7fffffff;
            row_v[i] = 8'(x >> 9);
        end
        row_v[17] = -8'sd128;
        run_row(32, "R8 deg32");
    endtask

    task automatic t_restart();
        // partial row without last, then a new row restarts
        @(negedge clk); drive(8'sd1, 1, 0);
        @(negedge clk); drive(-8'sd2, 0, 0);
        chk("R8 no output on partial row", out_valid, 0);
        @(negedge clk); drive(8'sd3, 0, 0);
        chk("R8 no output on partial row", out_valid, 0);
        row_v[0] = 8'sd60; row_v[1] = -8'sd45; row_v[2] = 8'sd70;
        run_row(3, "R8 restart");
    endtask

    task automatic t_overlap();
        row_v[0] = 8'sd12; row_v[1] = -8'sd33; row_v[2] = 8'sd8;  row_v[3] = 8'sd90;
        row_b[0] = -8'sd4; row_b[1] = -8'sd64; row_b[2] = 8'sd21; row_b[3] = -8'sd17;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (c < 4)      drive(row_v[c], c == 0, c == 3);
            else if (c < 8) drive(row_b[c-4], c == 4, c == 7);
            else            idle();
            if (c >= 4 && c < 8) chk_edge(row_v, 4, c - 4, "R10 row A");
            if (c >= 8)          chk_edge(row_b, 4, c - 8, "R10 row B");
        end
        @(negedge clk);
        chk("R10 end", out_valid, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_deg2();
        t_mixed();
        t_sat();
        t_tie();
        t_zero();
        t_deg32();
        t_restart();
        t_overlap();
        finish_run();
    end
endmodule